// File: doc/BRIEF.md
# Microsecond Interval Timer with Interrupt Group

This block is a register-mapped interval timer. A prescaler divides the system clock down to a 1 MHz tick. Software writes an interval in microseconds and a small control word, and the timer counts ticks until the interval has elapsed. That event is an overflow. Software reads the number of overflows since the last start from a read-only counter register. It does not read the live tick count.

Each overflow can do either or both of two things, as the control word selects. It can latch a pending flag in a four-register interrupt group, which has an enable, a write-only set, a write-only clear and a read-only status. It can also emit a one-cycle trigger pulse toward an external DMA engine. The timer runs either once or repeatedly, reloading the interval after each overflow.

Access is through a plain single-cycle register port: `wr_en`, a word address and 32-bit write data. Read data is driven combinationally from the address. Control register bits are 0 run, 1 periodic, 2 interrupt-on-overflow and 3 DMA-on-overflow.

Top module: `usec_interval_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` and `dma_req` are 0.
- R2: With divider D = CLK_HZ/TICK_HZ and interval N > 0, the write that starts the timer lands at clock edge E. The overflow counter then reads 0 until edge E+N·D and reads 1 from that edge.
- R3: With control bit 1 = 1, the timer overflows every N·D cycles without software action, and the counter rises by exactly 1 at each overflow.
- R4: With control bit 1 = 0, the timer stops after its first overflow. The counter stays at 1 and the control register still reads back bit 0 = 1.
- R5: A control write that changes bit 0 from 0 to 1 clears the overflow counter. Writing bit 0 = 0 halts counting, keeps the counter value, and stops all overflows.
- R6: An interval of 0 never produces an overflow: the counter, the status flag and `dma_req` all stay 0.
- R7: With control bit 2 = 1 an overflow sets the status flag (address 3, bit 0). With bit 2 = 0 an overflow leaves the flag unchanged.
- R8: With control bit 3 = 1, `dma_req` is high for exactly the one cycle after the overflow edge. With bit 3 = 0 it stays low.
- R9: `irq` equals status AND enable. Enable is address 0, bit 0. Writing 1 in bit 0 of address 1 sets the status, and writing 1 in bit 0 of address 2 clears it.
- R10: A clear write that lands on the same edge as an interrupt-raising overflow leaves the status at 0.
- R11: Address map: 0 enable, 1 set, 2 clear, 3 status, 4 control (bits 3:0, upper bits read 0), 5 interval (32 bits), 6 overflow count. Reads of addresses 1, 2 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Word address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, status AND enable |
| dma_req | output | 1 | One-cycle DMA trigger on overflow |

## Verification
A software clear of the status flag and an overflow that raises the flag can reach the interrupt group on the same clock edge. The bench starts a periodic timer with a one-microsecond interval and schedules the clear write so that it lands exactly on the first overflow edge. That this is the overflow edge is confirmed by the overflow counter reading 1 right after it. The status must read 0 after that edge, and must read 1 again after the next overflow, when no clear is pending.

// File: rtl/utmr_pkg.sv
`timescale 1ns/1ps
package utmr_pkg;
    localparam int REG_AW = 3;
    localparam int CTRL_W = 4;

    // control bit positions
    localparam int CB_RUN      = 0;
    localparam int CB_PERIODIC = 1;
    localparam int CB_IRQ      = 2;
    localparam int CB_DMA      = 3;

    typedef enum logic [REG_AW-1:0] {
        A_IRQ_EN   = 3'd0,
        A_IRQ_SET  = 3'd1,
        A_IRQ_CLR  = 3'd2,
        A_IRQ_STAT = 3'd3,
        A_CTRL     = 3'd4,
        A_IVAL     = 3'd5,
        A_OVFCNT   = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/utmr_prescaler.sv
`timescale 1ns/1ps
module utmr_prescaler #(
    parameter int CLK_HZ  = 200_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_s;

    pre_s pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = en && (pre_q.cnt == PW'(DIV - 1));
        if (!en || tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/utmr_core.sv
`timescale 1ns/1ps
module utmr_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             periodic,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    output logic             ovf,
    output logic             active,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] count;
        logic             done;
    } core_s;

    core_s core_d, core_q;
    logic [CNT_W:0] next_elapsed;

    always_comb begin
        core_d       = core_q;
        active       = run && !core_q.done;
        next_elapsed = {1'b0, core_q.elapsed} + 1'b1;
        ovf          = active && tick && (interval != '0)
                       && (next_elapsed >= {1'b0, interval});
        if (start) begin
            core_d.elapsed = '0;
            core_d.count   = '0;
            core_d.done    = 1'b0;
        end else if (!run) begin
            core_d.elapsed = '0;
            core_d.done    = 1'b0;
        end else if (ovf) begin
            core_d.elapsed = '0;
            core_d.count   = core_q.count + 1'b1;
            core_d.done    = !periodic;
        end else if (active && tick) begin
            core_d.elapsed = next_elapsed[CNT_W-1:0];
        end
    end

    assign count = core_q.count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end
endmodule

// File: rtl/utmr_irq.sv
`timescale 1ns/1ps
module utmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_we,
    input  logic en_val,
    input  logic set_req,
    input  logic clr_req,
    input  logic hw_set,
    output logic enable,
    output logic status,
    output logic irq
);
    typedef struct packed {
        logic enable;
        logic status;
    } irq_s;

    irq_s irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (en_we) irq_d.enable = en_val;
        // clear has priority over both set sources
        if (clr_req)                irq_d.status = 1'b0;
        else if (set_req || hw_set) irq_d.status = 1'b1;
    end

    assign enable = irq_q.enable;
    assign status = irq_q.status;
    assign irq    = irq_q.enable && irq_q.status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/usec_interval_timer.sv
`timescale 1ns/1ps
module usec_interval_timer
    import utmr_pkg::*;
#(
    parameter int CLK_HZ  = 200_000_000,
    parameter int TICK_HZ = 1_000_000,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              dma_req
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] interval;
        logic              dma;
    } top_s;

    top_s top_d, top_q;

    logic wr_ctrl, start, tick, ovf, active;
    logic irq_en_we, irq_set_we, irq_clr_we;
    logic irq_enable, irq_status;
    logic ctrl_run;
    logic [DATA_W-1:0] ival_now;
    logic [DATA_W-1:0] ovf_count;

    always_comb begin
        wr_ctrl    = wr_en && (addr == A_CTRL);
        start      = wr_ctrl && wdata[CB_RUN] && !top_q.ctrl[CB_RUN];
        irq_en_we  = wr_en && (addr == A_IRQ_EN);
        irq_set_we = wr_en && (addr == A_IRQ_SET) && wdata[0];
        irq_clr_we = wr_en && (addr == A_IRQ_CLR) && wdata[0];

        top_d     = top_q;
        top_d.dma = ovf && top_q.ctrl[CB_DMA];
        if (wr_ctrl)                      top_d.ctrl     = wdata[CTRL_W-1:0];
        if (wr_en && (addr == A_IVAL))    top_d.interval = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign ctrl_run = top_q.ctrl[CB_RUN];
    assign ival_now = top_q.interval;
    assign dma_req  = top_q.dma;

    utmr_prescaler #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .tick (tick)
    );

    utmr_core #(.CNT_W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (ctrl_run),
        .periodic(top_q.ctrl[CB_PERIODIC]),
        .tick    (tick),
        .interval(top_q.interval),
        .ovf     (ovf),
        .active  (active),
        .count   (ovf_count)
    );

    utmr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_we  (irq_en_we),
        .en_val (wdata[0]),
        .set_req(irq_set_we),
        .clr_req(irq_clr_we),
        .hw_set (ovf && top_q.ctrl[CB_IRQ]),
        .enable (irq_enable),
        .status (irq_status),
        .irq    (irq)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            A_IRQ_EN:   rdata = DATA_W'(irq_enable);
            A_IRQ_STAT: rdata = DATA_W'(irq_status);
            A_CTRL:     rdata = DATA_W'(top_q.ctrl);
            A_IVAL:     rdata = top_q.interval;
            A_OVFCNT:   rdata = ovf_count;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/utmr_chk.sv
`timescale 1ns/1ps
module utmr_chk
    import utmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic              wbit0,
    input logic              irq,
    input logic              dma_req,
    input logic              run,
    input logic [DATA_W-1:0] interval,
    input logic [DATA_W-1:0] count
);
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IRQ_CLR && wbit0) |=> !irq); // R10

    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IRQ_EN && !wbit0) |=> !irq); // R9

    AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req); // R8

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !dma_req); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0) |=> !dma_req); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0)); // R3
endmodule

bind usec_interval_timer utmr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wbit0   (wdata[0]),
    .irq     (irq),
    .dma_req (dma_req),
    .run     (ctrl_run),
    .interval(ival_now),
    .count   (ovf_count)
);

// File: tb/sim_usec_interval_timer.sv
`timescale 1ns/1ps
module sim_usec_interval_timer;
    localparam int CLK_HZ  = 200_000_000;
    localparam int TICK_HZ = 1_000_000;
    localparam int DIV     = CLK_HZ / TICK_HZ;

    // register addresses as stated in R11
    localparam logic [2:0] R_EN = 3'd0, R_SET = 3'd1, R_CLR = 3'd2, R_STAT = 3'd3,
                           R_CTRL = 3'd4, R_IVAL = 3'd5, R_CNT = 3'd6, R_NONE = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq, dma_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    usec_interval_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // write lands on the next rising edge; returns 1 ns after it
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // combinational read, consumes no clock edge
    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reg %0d after reset", a), v, 32'd0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 dma_req after reset", {31'd0, dma_req}, 32'd0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(R_IVAL, 32'hA5A5_0005);
        rd(R_IVAL, v);   chk("R11 interval readback", v, 32'hA5A5_0005);
        wr(R_CTRL, 32'hFFFF_FFFE);
        rd(R_CTRL, v);   chk("R11 control masked to 4 bits", v, 32'h0000_000E);
        rd(R_SET, v);    chk("R11 set reads 0", v, 32'd0);
        rd(R_CLR, v);    chk("R11 clear reads 0", v, 32'd0);
        rd(R_NONE, v);   chk("R11 unused address reads 0", v, 32'd0);
        wr(R_CTRL, 32'd0);
    endtask

    // one-shot with DMA, interval 3
    task automatic t_oneshot;
        logic [31:0] v;
        int dma_seen;
        wr(R_IVAL, 32'd3);
        wr(R_CTRL, 32'h9);
        cycles(3 * DIV - 1);
        rd(R_CNT, v);    chk("R2 count before first overflow", v, 32'd0);
        chk("R8 dma_req low before overflow", {31'd0, dma_req}, 32'd0);
        cycles(1);
        rd(R_CNT, v);    chk("R2 count at first overflow", v, 32'd1);
        chk("R8 dma_req pulse", {31'd0, dma_req}, 32'd1);
        cycles(1);
        chk("R8 dma_req single cycle", {31'd0, dma_req}, 32'd0);
        dma_seen = 0;
        for (int i = 0; i < 4 * DIV; i++) begin
            cycles(1);
            if (dma_req) dma_seen++;
        end
        chk("R4 one-shot no further dma", 32'(dma_seen), 32'd0);
        rd(R_CNT, v);    chk("R4 one-shot count stays 1", v, 32'd1);
        rd(R_CTRL, v);   chk("R4 control bit 0 still set", v, 32'h9);
        wr(R_CTRL, 32'd0);
    endtask

    // periodic without IRQ or DMA, interval 2
    task automatic t_periodic;
        logic [31:0] v;
        wr(R_IVAL, 32'd2);
        wr(R_CTRL, 32'h3);
        rd(R_CNT, v);    chk("R5 start clears count", v, 32'd0);
        cycles(3 * 2 * DIV);
        rd(R_CNT, v);    chk("R3 periodic count after 3 intervals", v, 32'd3);
        rd(R_STAT, v);   chk("R7 status unchanged without bit 2", v, 32'd0);
        chk("R8 no dma without bit 3", {31'd0, dma_req}, 32'd0);
        wr(R_CTRL, 32'h2);
        cycles(4 * DIV * 2);
        rd(R_CNT, v);    chk("R5 stop holds count", v, 32'd3);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        int dma_seen;
        wr(R_IVAL, 32'd0);
        wr(R_CTRL, 32'hF);
        dma_seen = 0;
        for (int i = 0; i < 10 * DIV; i++) begin
            cycles(1);
            if (dma_req) dma_seen++;
        end
        chk("R6 zero interval no dma", 32'(dma_seen), 32'd0);
        rd(R_CNT, v);    chk("R6 zero interval count", v, 32'd0);
        rd(R_STAT, v);   chk("R6 zero interval status", v, 32'd0);
        wr(R_CTRL, 32'd0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(R_EN, 32'd1);
        wr(R_IVAL, 32'd1);
        wr(R_CTRL, 32'h5);
        cycles(DIV + 2);
        rd(R_STAT, v);   chk("R7 overflow sets status", v, 32'd1);
        chk("R9 irq with enable", {31'd0, irq}, 32'd1);
        wr(R_EN, 32'd0);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        rd(R_STAT, v);   chk("R9 status kept while masked", v, 32'd1);
        wr(R_EN, 32'd1);
        chk("R9 irq unmasked", {31'd0, irq}, 32'd1);
        wr(R_CLR, 32'd1);
        chk("R9 clear drops irq", {31'd0, irq}, 32'd0);
        wr(R_SET, 32'd1);
        rd(R_STAT, v);   chk("R9 set raises status", v, 32'd1);
        chk("R9 set raises irq", {31'd0, irq}, 32'd1);
        wr(R_CLR, 32'd1);
        wr(R_CTRL, 32'd0);
    endtask

    // clear write lands on the overflow edge
    task automatic t_race;
        logic [31:0] v;
        wr(R_IVAL, 32'd1);
        wr(R_CTRL, 32'h7);
        repeat (DIV - 1) @(posedge clk);
        wr(R_CLR, 32'd1);
        rd(R_CNT, v);    chk("R10 clear lands on overflow edge", v, 32'd1);
        rd(R_STAT, v);   chk("R10 clear wins over overflow", v, 32'd0);
        chk("R10 irq low after race", {31'd0, irq}, 32'd0);
        cycles(DIV);
        rd(R_CNT, v);    chk("R3 second periodic overflow", v, 32'd2);
        rd(R_STAT, v);   chk("R10 next overflow sets status", v, 32'd1);
        wr(R_CTRL, 32'd0);
        wr(R_CLR, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_oneshot;
        t_periodic;
        t_zero;
        t_irq;
        t_race;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule